// File: doc/BRIEF.md
# Geometry Coprocessor Register File

This block holds the 64 working registers of a fixed-point geometry coprocessor. Each register is 32 bits wide. Access is through one write port and one read port, and each port takes its own 6-bit index. The block does not execute any commands. It stores data, and it applies the access rule that belongs to each index.

Most indices are plain storage. Several indices transform the value on its way in:
- Some keep a 16-bit value and sign-extend it.
- Some keep a 16-bit value and zero-extend it.
- One index pushes a three-deep screen-coordinate queue.
- One index unpacks a 5:5:5 colour into three intermediate registers.
- One index triggers a leading-bit count.
- One index holds a status word with a computed error summary bit.

Two indices are read-only. Some reads are computed rather than stored. The read port is registered. A read returns the contents as they stood before any write taking effect at the same clock edge.

Top module: `cop_regfile`

## Requirements
- R1: A synchronous reset clears every entry and the read data to zero; after reset, a read of any index returns 0.
- R2: Read data appears one clock after `rd_addr` is presented. A write to the same index at that same edge is not yet visible; it is visible to the next read.
- R3: Writes to indices 1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61 and 62 store bits 15:0 of the data, sign-extended to 32 bits.
- R4: Writes to indices 7, 16, 17, 18 and 19 store bits 15:0 of the data, zero-extended to 32 bits.
- R5: A write to index 15 does three things. Entry 13 moves into entry 12, entry 14 moves into entry 13, and the written value lands in entry 14. A read of index 15 returns entry 14.
- R6: A write to index 28 takes three 5-bit fields: bits 4:0, bits 9:5 and bits 14:10. Each field, times 0x80, is written into entry 9, 10 and 11 respectively.
- R7: A read of index 28 or 29 returns a packed word {b, g, r}, with r in bits 4:0, g in bits 9:5 and b in bits 14:10. The upper bits are zero. Each field is entry 9, 10 or 11 divided by 0x80 and clamped to 0..31; a negative entry gives 0.
- R8: A write to index 30 stores the value. It also sets entry 31 to the number of leading bits equal to bit 31, which is 32 when all bits are equal.
- R9: Writes to indices 29 and 31 are ignored.
- R10: A write to index 63 keeps bits 30:12 and clears bits 11:0. Bit 31 becomes the OR of the kept bits selected by `ERR_MASK`; the default mask selects bits 30:23 and 18:13.
- R11: All other indices store the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read index |
| rd_data | output | 32 | Registered read data |

## Verification
The extension rules are tried with data whose bit 15 is set and with data whose bit 15 is clear, each with non-zero upper bits. This separates sign extension, zero extension and plain storage.

The colour path is tried three ways:
- Intermediate values that are in range.
- A negative value.
- A value too large for the field, which separates the divide from the two clamps.

A colour round trip then checks that unpacking and packing agree.

The leading-bit count is tried with four kinds of value:
- all zeros;
- all ones;
- a positive value;
- a negative value.

This separates counting ones from counting zeros and covers the full-width case. Status words with only masked bits set, only unmasked bits set, or only low bits set separate the summary bit from the bit masking.

// File: rtl/cop_rf_pkg.sv
package cop_rf_pkg;

   typedef enum logic [2:0] {
      WK_PLAIN, WK_SEXT, WK_ZEXT, WK_PUSH, WK_COLOR, WK_LZC, WK_RO, WK_FLAG
   } wr_kind_e;

   localparam int unsigned IX_IR1   = 9;
   localparam int unsigned IX_IR2   = 10;
   localparam int unsigned IX_IR3   = 11;
   localparam int unsigned IX_SCR0  = 12;
   localparam int unsigned IX_SCR1  = 13;
   localparam int unsigned IX_SCR2  = 14;
   localparam int unsigned IX_SPUSH = 15;
   localparam int unsigned IX_CIN   = 28;
   localparam int unsigned IX_COUT  = 29;
   localparam int unsigned IX_LSRC  = 30;
   localparam int unsigned IX_LCNT  = 31;
   localparam int unsigned IX_STAT  = 63;

   function automatic wr_kind_e classify(input logic [5:0] a);
      case (a)
         6'd1, 6'd3, 6'd5, 6'd8, 6'd9, 6'd10, 6'd11,
         6'd36, 6'd44, 6'd52, 6'd58, 6'd59, 6'd61, 6'd62: classify = WK_SEXT;
         6'd7, 6'd16, 6'd17, 6'd18, 6'd19:               classify = WK_ZEXT;
         6'(IX_SPUSH):                                   classify = WK_PUSH;
         6'(IX_CIN):                                     classify = WK_COLOR;
         6'(IX_LSRC):                                    classify = WK_LZC;
         6'(IX_COUT), 6'(IX_LCNT):                       classify = WK_RO;
         6'(IX_STAT):                                    classify = WK_FLAG;
         default:                                        classify = WK_PLAIN;
      endcase
   endfunction

endpackage

// File: rtl/cop_rf_lzc.sv
module cop_rf_lzc #(
   parameter int W     = 32,
   localparam int CNT_W = $clog2(W) + 1
) (
   input  logic [W-1:0]     value,
   output logic [CNT_W-1:0] count
);
   logic [W-1:0] norm;
   logic         found;

   always_comb begin
      norm  = value[W-1] ? ~value : value;
      count = CNT_W'(W);
      found = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (!found && norm[i]) begin
            count = CNT_W'(W - 1 - i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cop_rf_color.sv
module cop_rf_color #(
   parameter int DATA_W  = 32,
   parameter int HALF_W  = 16,
   parameter int CHAN_W  = 5,
   parameter int CHAN_SH = 7,
   parameter int NCH     = 3,
   localparam int PK_W   = NCH * CHAN_W
) (
   input  logic [PK_W-1:0]       packed_in,
   input  logic [NCH*DATA_W-1:0] chan_in,
   output logic [NCH*DATA_W-1:0] chan_out,
   output logic [PK_W-1:0]       packed_out
);
   if (CHAN_W + CHAN_SH > HALF_W) begin : g_bad_scale
      $error("cop_rf_color: scaled channel exceeds half word");
   end
   if (DATA_W <= CHAN_W + CHAN_SH) begin : g_bad_width
      $error("cop_rf_color: data width too small");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CHAN_W-1:0] fin;
      logic [HALF_W-1:0] scaled;
      logic [DATA_W-1:0] ent;
      logic [DATA_W-1:0] quo;

      assign fin    = packed_in[c*CHAN_W +: CHAN_W];
      assign scaled = HALF_W'({fin, {CHAN_SH{1'b0}}});
      assign chan_out[c*DATA_W +: DATA_W] =
         {{(DATA_W-HALF_W){scaled[HALF_W-1]}}, scaled};

      assign ent = chan_in[c*DATA_W +: DATA_W];
      assign quo = ent >> CHAN_SH;

      always_comb begin
         if (ent[DATA_W-1])
            packed_out[c*CHAN_W +: CHAN_W] = '0;
         else if (|quo[DATA_W-1:CHAN_W])
            packed_out[c*CHAN_W +: CHAN_W] = '1;
         else
            packed_out[c*CHAN_W +: CHAN_W] = quo[CHAN_W-1:0];
      end
   end
endmodule

// File: rtl/cop_rf_flag.sv
module cop_rf_flag #(
   parameter int              DATA_W   = 32,
   parameter int              FLAG_LO  = 12,
   parameter int              FLAG_HI  = 30,
   parameter logic [DATA_W-1:0] ERR_MASK = 32'h7F87E000
) (
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] flag_out
);
   function automatic logic [DATA_W-1:0] span(input int lo, input int hi);
      span = '0;
      for (int i = lo; i <= hi; i++) span[i] = 1'b1;
   endfunction

   localparam logic [DATA_W-1:0] KEEP = span(FLAG_LO, FLAG_HI);

   if (FLAG_HI + 1 >= DATA_W) begin : g_bad_range
      $error("cop_rf_flag: no room for summary bit");
   end
   if ((ERR_MASK & ~KEEP) != '0) begin : g_bad_mask
      $error("cop_rf_flag: ERR_MASK outside kept range");
   end

   logic [DATA_W-1:0] kept;
   assign kept = raw & KEEP;

   always_comb begin
      flag_out = kept;
      flag_out[DATA_W-1] = |(kept & ERR_MASK);
   end
endmodule

// File: rtl/cop_regfile.sv
module cop_regfile
   import cop_rf_pkg::*;
#(
   parameter int              ADDR_W   = 6,
   parameter int              DATA_W   = 32,
   parameter int              HALF_W   = 16,
   parameter int              CHAN_W   = 5,
   parameter int              CHAN_SH  = 7,
   parameter int              FLAG_LO  = 12,
   parameter int              FLAG_HI  = 30,
   parameter logic [DATA_W-1:0] ERR_MASK = 32'h7F87E000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int NCH   = 3;
   localparam int PK_W  = NCH * CHAN_W;
   localparam int CNT_W = $clog2(DATA_W) + 1;

   if (ADDR_W != 6) begin : g_bad_addr
      $error("cop_regfile: index map needs ADDR_W of 6");
   end
   if (DATA_W != 2 * HALF_W) begin : g_bad_data
      $error("cop_regfile: DATA_W must be twice HALF_W");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   logic [CNT_W-1:0]      lzc_cnt;
   logic [NCH*DATA_W-1:0] unpacked;
   logic [PK_W-1:0]       packed_rd;
   logic [DATA_W-1:0]     flag_wr;
   logic [DATA_W-1:0]     rd_next;
   wr_kind_e              kind;

   cop_rf_lzc #(.W(DATA_W)) u_lzc (
      .value (wr_data),
      .count (lzc_cnt)
   );

   cop_rf_color #(
      .DATA_W (DATA_W), .HALF_W (HALF_W), .CHAN_W (CHAN_W),
      .CHAN_SH(CHAN_SH), .NCH (NCH)
   ) u_color (
      .packed_in  (wr_data[PK_W-1:0]),
      .chan_in    ({mem[IX_IR3], mem[IX_IR2], mem[IX_IR1]}),
      .chan_out   (unpacked),
      .packed_out (packed_rd)
   );

   cop_rf_flag #(
      .DATA_W (DATA_W), .FLAG_LO (FLAG_LO), .FLAG_HI (FLAG_HI),
      .ERR_MASK (ERR_MASK)
   ) u_flag (
      .raw      (wr_data),
      .flag_out (flag_wr)
   );

   assign kind = classify(wr_addr);

   always_comb begin
      case (rd_addr)
         ADDR_W'(IX_SPUSH):                   rd_next = mem[IX_SCR2];
         ADDR_W'(IX_CIN), ADDR_W'(IX_COUT):   rd_next = DATA_W'(packed_rd);
         default:                             rd_next = mem[rd_addr];
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rd_data <= '0;
      end else begin
         rd_data <= rd_next;
         if (wr_en) begin
            case (kind)
               WK_SEXT:
                  mem[wr_addr] <= {{HALF_W{wr_data[HALF_W-1]}}, wr_data[HALF_W-1:0]};
               WK_ZEXT:
                  mem[wr_addr] <= {{HALF_W{1'b0}}, wr_data[HALF_W-1:0]};
               WK_PUSH: begin
                  mem[IX_SCR0] <= mem[IX_SCR1];
                  mem[IX_SCR1] <= mem[IX_SCR2];
                  mem[IX_SCR2] <= wr_data;
               end
               WK_COLOR: begin
                  mem[IX_CIN] <= DATA_W'(wr_data[PK_W-1:0]);
                  mem[IX_IR1] <= unpacked[0*DATA_W +: DATA_W];
                  mem[IX_IR2] <= unpacked[1*DATA_W +: DATA_W];
                  mem[IX_IR3] <= unpacked[2*DATA_W +: DATA_W];
               end
               WK_LZC: begin
                  mem[IX_LSRC] <= wr_data;
                  mem[IX_LCNT] <= DATA_W'(lzc_cnt);
               end
               WK_RO: ;
               WK_FLAG:
                  mem[IX_STAT] <= flag_wr;
               WK_PLAIN:
                  mem[wr_addr] <= wr_data;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cop_regfile_chk.sv
module cop_regfile_chk #(
   parameter int              ADDR_W   = 6,
   parameter int              DATA_W   = 32,
   parameter int              HALF_W   = 16,
   parameter int              FLAG_LO  = 12,
   parameter logic [DATA_W-1:0] ERR_MASK = 32'h7F87E000
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> rd_data == '0); // R1

   AST_SEXT_FORM: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_addr) inside {6'd1, 6'd3, 6'd5, 6'd8, 6'd9, 6'd10, 6'd11,
                              6'd36, 6'd44, 6'd52, 6'd58, 6'd59, 6'd61, 6'd62})
      |-> rd_data[DATA_W-1:HALF_W] == {HALF_W{rd_data[HALF_W-1]}}); // R3

   AST_ZEXT_FORM: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_addr) inside {6'd7, 6'd16, 6'd17, 6'd18, 6'd19})
      |-> rd_data[DATA_W-1:HALF_W] == '0); // R4

   AST_PACK_FORM: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_addr) inside {6'd28, 6'd29}) |-> rd_data[DATA_W-1:15] == '0); // R7

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_addr) == 6'd31) |-> rd_data <= DATA_W); // R8

   AST_STATUS_FORM: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_addr) == 6'd63) |->
         (rd_data[FLAG_LO-1:0] == '0 &&
          rd_data[DATA_W-1] == |(rd_data & ERR_MASK))); // R10
endmodule

bind cop_regfile cop_regfile_chk #(
   .ADDR_W (ADDR_W), .DATA_W (DATA_W), .HALF_W (HALF_W),
   .FLAG_LO (FLAG_LO), .ERR_MASK (ERR_MASK)
) u_chk (
   .clk (clk), .rst (rst), .rd_addr (rd_addr), .rd_data (rd_data)
);

// File: tb/test_cop_regfile.sv
module test_cop_regfile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cop_regfile i_cop_regfile (
      .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk);
      rd_addr = a;
      @(posedge clk);
      @(negedge clk);
      check(req, rd_data, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 idx0", 6'd0, 32'h0);
      rd_chk("R1 idx9", 6'd9, 32'h0);
      rd_chk("R1 idx63", 6'd63, 32'h0);
      rd_chk("R1 idx15", 6'd15, 32'h0);
   endtask

   task automatic t_plain;
      wr(6'd40, 32'hDEADBEEF);
      rd_chk("R11 idx40", 6'd40, 32'hDEADBEEF);
      wr(6'd0, 32'h8000_8001);
      rd_chk("R11 idx0", 6'd0, 32'h8000_8001);
   endtask

   task automatic t_same_edge;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd40; wr_data = 32'h1234_5678; rd_addr = 6'd40;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 old value", rd_data, 32'hDEADBEEF);
      rd_chk("R2 new value", 6'd40, 32'h1234_5678);
   endtask

   task automatic t_extend;
      wr(6'd1, 32'h1234_8001);
      rd_chk("R3 neg", 6'd1, 32'hFFFF_8001);
      wr(6'd58, 32'hFFFF_7FFF);
      rd_chk("R3 pos", 6'd58, 32'h0000_7FFF);
      wr(6'd62, 32'h0000_FFFF);
      rd_chk("R3 idx62", 6'd62, 32'hFFFF_FFFF);
      wr(6'd7, 32'hABCD_F00F);
      rd_chk("R4 idx7", 6'd7, 32'h0000_F00F);
      wr(6'd19, 32'hFFFF_8000);
      rd_chk("R4 idx19", 6'd19, 32'h0000_8000);
   endtask

   task automatic t_push;
      wr(6'd15, 32'h0000_0011);
      wr(6'd15, 32'h0000_0022);
      wr(6'd15, 32'hC000_0033);
      rd_chk("R5 e12", 6'd12, 32'h0000_0011);
      rd_chk("R5 e13", 6'd13, 32'h0000_0022);
      rd_chk("R5 e14", 6'd14, 32'hC000_0033);
      rd_chk("R5 rd15", 6'd15, 32'hC000_0033);
      wr(6'd15, 32'h0000_0044);
      rd_chk("R5 shift e12", 6'd12, 32'h0000_0022);
   endtask

   task automatic t_color;
      wr(6'd9,  32'h0000_0100);
      wr(6'd10, 32'h0000_8000);
      wr(6'd11, 32'h0000_7FFF);
      rd_chk("R7 pack29", 6'd29, 32'h0000_7C02);
      rd_chk("R7 pack28", 6'd28, 32'h0000_7C02);
      wr(6'd28, 32'hFFFF_7C1F);
      rd_chk("R6 e9", 6'd9, 32'h0000_0F80);
      rd_chk("R6 e10", 6'd10, 32'h0000_0000);
      rd_chk("R6 e11", 6'd11, 32'h0000_0F80);
      rd_chk("R7 roundtrip", 6'd28, 32'h0000_7C1F);
      wr(6'd28, 32'h0000_0CA5);
      rd_chk("R6 mixed e10", 6'd10, 32'h0000_0280);
      rd_chk("R7 mixed", 6'd29, 32'h0000_0CA5);
   endtask

   task automatic t_lzc;
      wr(6'd30, 32'h0000_0000);
      rd_chk("R8 zeros", 6'd31, 32'd32);
      wr(6'd30, 32'hFFFF_FFFF);
      rd_chk("R8 ones", 6'd31, 32'd32);
      wr(6'd30, 32'h0001_0000);
      rd_chk("R8 pos", 6'd31, 32'd15);
      rd_chk("R8 stored", 6'd30, 32'h0001_0000);
      wr(6'd30, 32'hF000_0000);
      rd_chk("R8 neg", 6'd31, 32'd4);
   endtask

   task automatic t_readonly;
      wr(6'd31, 32'h0000_0055);
      rd_chk("R9 idx31", 6'd31, 32'd4);
      wr(6'd29, 32'h0000_0000);
      rd_chk("R9 idx29", 6'd29, 32'h0000_0CA5);
      rd_chk("R9 ir1 kept", 6'd9, 32'h0000_0280);
   endtask

   task automatic t_status;
      wr(6'd63, 32'hFFFF_FFFF);
      rd_chk("R10 all", 6'd63, 32'hFFFF_F000);
      wr(6'd63, 32'h0000_1000);
      rd_chk("R10 unmasked", 6'd63, 32'h0000_1000);
      wr(6'd63, 32'h0000_2000);
      rd_chk("R10 masked", 6'd63, 32'h8000_2000);
      wr(6'd63, 32'h0000_0FFF);
      rd_chk("R10 low", 6'd63, 32'h0000_0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_plain();
      t_same_edge();
      t_extend();
      t_push();
      t_color();
      t_lzc();
      t_readonly();
      t_status();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule